// File: doc/BRIEF.md
# Prescaled Timer with Toggle Output

A down-counting interval timer that runs from a time base of one eighth of the system clock. A programmable prescaler divides that time base by 1 to 64. Its wrap pulses drive an 8-bit counter that divides by 1 to 256. When the counter runs out, the block emits a one-cycle interrupt request. The same end-of-count event inverts a toggle flip-flop. The time from a load to the end of count is therefore 8 × prescale × count system clock cycles.

A single output pin can carry the toggle flip-flop, the divide-by-8 time-base clock, or a general-purpose data bit. A 2-bit select field in the mode register makes the choice, and a pin-enable input can also force the data bit. A load bit in the mode register restarts the timer and presets the toggle output to 1. In continuous mode the counter reloads itself at each end of count, so a constant reload value gives a square wave with 50% duty. Writing a new count value between ends of count reshapes the duty cycle.

Software reaches the block through a write port with three addresses: 0 is the mode register, 1 is the prescale value and 2 is the count value.

Top module: `toggle_timer`

## Requirements
- R1: After reset the interrupt output is 0, the output select is 00 and the pin follows `gpData`.
- R2: Mode bits [7:6] choose the pin source: 00 and the reserved code 01 both pass `gpData`, 10 passes the toggle flip-flop and 11 passes the time-base clock. When `pinIsOut` is 0, the pin passes `gpData` whatever the select.
- R3: Writing the mode register (address 0) with bit 2 set restarts the timer from the stored prescale and count values, even if it is already running, and the toggle output reads 1 in the cycle after the write. A mode write with bit 2 clear leaves the timing and the toggle output unchanged.
- R4: The first interrupt pulse comes exactly 8 × P × V clock cycles after the load write edge, where P is the prescale value (address 1, bits [5:0]) and V is the count value (address 2). The pulse lasts one cycle.
- R5: A prescale value of 0 divides by 64, and a count value of 0 divides by 256.
- R6: The toggle flip-flop inverts in the same cycle as each interrupt pulse.
- R7: With mode bit 0 set (continuous), the counter reloads at each end of count, so interrupts repeat every 8 × P × V cycles and the toggle output is high for half of each two-period cycle.
- R8: With mode bit 0 clear (single pass), the timer stops at end of count and raises no further interrupt until the next load.
- R9: A count value written while the timer runs in continuous mode is used from the next reload on. The period in progress keeps its old length.
- R10: Select code 11 drives the pin with a clock of one eighth of the system clock frequency, high for 4 cycles and low for 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0 mode, 1 prescale, 2 count |
| wrData | input | 8 | Register write data |
| gpData | input | 1 | General-purpose data bit for the pin |
| pinIsOut | input | 1 | 1 lets the timer sources reach the pin |
| irqPulse | output | 1 | One-cycle end-of-count interrupt request |
| pinOut | output | 1 | Selected output pin level |

## Verification
The embedded properties check, on every cycle, that the interrupt lasts one cycle and that the toggle inverts with it. They also check that a load presets the toggle and starts the timer, that single-pass operation drops the run flag at end of count, that the time-base tick never fires twice in a row, and that both down-counters stay within their legal ranges. The exact end-of-count cycle for a given prescale and count can only be shown by the bench's scenarios. The same goes for the 0-encodes-maximum cases, the deferred effect of a count write, the restart while running, the 50% duty measurement and the source selection at the pin. The bench's scoreboard predicts each interrupt cycle and the pin level that goes with it.

// File: rtl/toggle_timer_pkg.sv
package toggle_timer_pkg;

  // Pin source select, mode register bits [7:6]
  typedef enum logic [1:0] {
    SEL_OFF    = 2'b00,
    SEL_RSVD   = 2'b01,
    SEL_TOGGLE = 2'b10,
    SEL_CLK    = 2'b11
  } pinSel_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic load;   // restart counters, preset toggle
    logic tick;   // one time-base step while running
  } tmrStrobe_t;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_PRE  = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;

  localparam int LOAD_BIT = 2;
  localparam int CONT_BIT = 0;
  localparam int SEL_LSB  = 6;

endpackage

// File: rtl/toggle_timer_ctrl.sv
module toggle_timer_ctrl
  import toggle_timer_pkg::*;
#(
  parameter int PRE_W  = 6,
  parameter int CNT_W  = 8,
  parameter int DIV_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              eoc,
  output tmrStrobe_t        strobe,
  output pinSel_e           pinSel,
  output logic [PRE_W-1:0]  preVal,
  output logic [CNT_W-1:0]  cntVal,
  output logic              baseClk
);

  logic [DIV_W-1:0] divQ;
  logic             runQ;
  logic             contQ;
  pinSel_e          selQ;
  logic [PRE_W-1:0] preRegQ;
  logic [CNT_W-1:0] cntRegQ;

  logic modeWr, loadStb, baseTick;

  assign modeWr   = wrEn && (wrAddr == ADDR_MODE);
  assign loadStb  = modeWr && wrData[LOAD_BIT];
  assign baseTick = (divQ == {DIV_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divQ    <= '0;
      runQ    <= 1'b0;
      contQ   <= 1'b0;
      selQ    <= SEL_OFF;
      preRegQ <= '0;
      cntRegQ <= '0;
    end else begin
      // Time base restarts with each load so the interval is exact
      if (loadStb) divQ <= '0;
      else         divQ <= divQ + 1'b1;

      if (modeWr) begin
        selQ  <= pinSel_e'(wrData[SEL_LSB+1:SEL_LSB]);
        contQ <= wrData[CONT_BIT];
      end
      if (wrEn && (wrAddr == ADDR_PRE)) preRegQ <= wrData[PRE_W-1:0];
      if (wrEn && (wrAddr == ADDR_CNT)) cntRegQ <= wrData[CNT_W-1:0];

      if (loadStb)            runQ <= 1'b1;
      else if (eoc && !contQ) runQ <= 1'b0;
    end
  end

  assign strobe.load = loadStb;
  assign strobe.tick = baseTick && runQ;
  assign pinSel      = selQ;
  assign preVal      = preRegQ;
  assign cntVal      = cntRegQ;
  assign baseClk     = divQ[DIV_W-1];

  // R3: a load always leaves the timer running
  p_load_runs_r3: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> runQ);

  // R8: single pass drops the run flag at end of count
  p_single_stops_r8: assert property (@(posedge clk) disable iff (!rstN)
    (eoc && !contQ && !loadStb) |=> !runQ);

  // R4: time-base steps are isolated single-cycle events
  p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rstN)
    baseTick |=> !baseTick);

endmodule

// File: rtl/toggle_timer_dp.sv
module toggle_timer_dp
  import toggle_timer_pkg::*;
#(
  parameter int PRE_W = 6,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic [PRE_W-1:0] preVal,
  input  logic [CNT_W-1:0] cntVal,
  input  pinSel_e          pinSel,
  input  logic             baseClk,
  input  logic             gpData,
  input  logic             pinIsOut,
  output logic             eoc,
  output logic             irqPulse,
  output logic             pinOut
);

  localparam int PRE_CW = PRE_W + 1;
  localparam int CNT_CW = CNT_W + 1;
  localparam logic [PRE_CW-1:0] PRE_ONE = 1;
  localparam logic [CNT_CW-1:0] CNT_ONE = 1;
  localparam logic [PRE_CW-1:0] PRE_MAX = {1'b1, {PRE_W{1'b0}}};
  localparam logic [CNT_CW-1:0] CNT_MAX = {1'b1, {CNT_W{1'b0}}};

  logic [PRE_CW-1:0] preCnt;
  logic [CNT_CW-1:0] cntRem;
  logic [PRE_CW-1:0] preLoad;
  logic [CNT_CW-1:0] cntLoad;
  logic              toggleQ;
  logic              irqQ;
  logic              preWrap;

  // A zero field encodes the full range (2**W)
  assign preLoad = {(preVal == '0), preVal};
  assign cntLoad = {(cntVal == '0), cntVal};

  assign preWrap = strobe.tick && (preCnt == PRE_ONE);
  assign eoc     = preWrap && (cntRem == CNT_ONE) && !strobe.load;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt  <= PRE_ONE;
      cntRem  <= CNT_ONE;
      toggleQ <= 1'b0;
      irqQ    <= 1'b0;
    end else if (strobe.load) begin
      preCnt  <= preLoad;
      cntRem  <= cntLoad;
      toggleQ <= 1'b1;
      irqQ    <= 1'b0;
    end else begin
      irqQ <= eoc;
      if (eoc) toggleQ <= ~toggleQ;
      if (strobe.tick) preCnt <= preWrap ? preLoad : (preCnt - PRE_ONE);
      if (preWrap)     cntRem <= (cntRem == CNT_ONE) ? cntLoad : (cntRem - CNT_ONE);
    end
  end

  always_comb begin
    pinOut = gpData;
    if (pinIsOut) begin
      case (pinSel)
        SEL_TOGGLE: pinOut = toggleQ;
        SEL_CLK:    pinOut = baseClk;
        default:    pinOut = gpData;
      endcase
    end
  end

  assign irqPulse = irqQ;

  // R4: the interrupt request never lasts more than one cycle
  p_irq_one_cycle_r4: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  // R6: the toggle flips together with each interrupt
  p_toggle_on_eoc_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (toggleQ != $past(toggleQ)));

  // R3: a load presets the toggle to 1
  p_load_presets_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> toggleQ);

  // R5: down-counters stay within 1..2**W
  p_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    (preCnt != '0) && (preCnt <= PRE_MAX) && (cntRem != '0) && (cntRem <= CNT_MAX));

endmodule

// File: rtl/toggle_timer.sv
module toggle_timer
  import toggle_timer_pkg::*;
#(
  parameter int PRE_W  = 6,
  parameter int CNT_W  = 8,
  parameter int DIV_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              gpData,
  input  logic              pinIsOut,
  output logic              irqPulse,
  output logic              pinOut
);

  tmrStrobe_t       strobe;
  pinSel_e          pinSel;
  logic [PRE_W-1:0] preVal;
  logic [CNT_W-1:0] cntVal;
  logic             baseClk;
  logic             eoc;

  toggle_timer_ctrl #(
    .PRE_W(PRE_W), .CNT_W(CNT_W), .DIV_W(DIV_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .eoc(eoc), .strobe(strobe), .pinSel(pinSel), .preVal(preVal),
    .cntVal(cntVal), .baseClk(baseClk)
  );

  toggle_timer_dp #(
    .PRE_W(PRE_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .preVal(preVal), .cntVal(cntVal),
    .pinSel(pinSel), .baseClk(baseClk), .gpData(gpData), .pinIsOut(pinIsOut),
    .eoc(eoc), .irqPulse(irqPulse), .pinOut(pinOut)
  );

endmodule

// File: tb/toggle_timer_bench.sv
module toggle_timer_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic       gpData = 1'b0;
  logic       pinIsOut = 1'b1;
  logic       irqPulse, pinOut;

  toggle_timer u_toggle_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .gpData(gpData), .pinIsOut(pinIsOut), .irqPulse(irqPulse), .pinOut(pinOut)
  );

  always #5 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct {
    int unsigned at;
    bit          lvl;
    string       tag;
  } expIrq_t;
  expIrq_t expQ[$];

  task automatic checkBit(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic checkNum(input string tag, input int unsigned act, input int unsigned exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected interrupt per observed pulse
  always @(negedge clk) begin
    if (rstN && irqPulse === 1'b1) begin
      if (expQ.size() == 0) begin
        nChecks++;
        nFails++;
        $display("FAIL R8: interrupt at cycle %0d, actual 1 expected 0", cyc);
      end else begin
        expIrq_t e;
        e = expQ.pop_front();
        checkNum({e.tag, " irq cycle"}, cyc, e.at);
        checkBit({e.tag, " toggle level"}, pinOut, e.lvl);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d, output int unsigned edgeIdx);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    edgeIdx = cyc;
  endtask

  task automatic waitUntil(input int unsigned t);
    while (cyc < t) @(negedge clk);
  endtask

  // Driver: program and load, then push the predicted interrupts
  task automatic startTimer(input int p, input int v, input bit cont, input int nEoc,
                            input string tag, output int unsigned w);
    int unsigned dummy, per;
    int pe, ve;
    wr(2'd1, 8'(p), dummy);
    wr(2'd2, 8'(v), dummy);
    wr(2'd0, {2'b10, 3'b000, 1'b1, 1'b0, cont}, w);
    pe = (p == 0) ? 64 : p;
    ve = (v == 0) ? 256 : v;
    per = 8 * pe * ve;
    for (int k = 1; k <= nEoc; k++) begin
      expIrq_t e;
      e.at = w + per * k; e.lvl = (k % 2 == 0); e.tag = tag;
      expQ.push_back(e);
    end
  endtask

  task automatic pushExp(input int unsigned at, input bit lvl, input string tag);
    expIrq_t e;
    e.at = at; e.lvl = lvl; e.tag = tag;
    expQ.push_back(e);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int unsigned w, w2, dummy;
    int ones, edges;
    logic prev;

    // R1: reset state
    repeat (3) @(negedge clk);
    checkBit("R1 irq in reset", irqPulse, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkBit("R1 irq after reset", irqPulse, 1'b0);
    checkBit("R1 pin follows gpData=0", pinOut, 1'b0);
    gpData = 1'b1; #1;
    checkBit("R1 pin follows gpData=1", pinOut, 1'b1);

    // R2: select codes off and reserved, and pin-enable override
    wr(2'd0, 8'h00, dummy);
    gpData = 1'b0; #1; checkBit("R2 sel 00 gp0", pinOut, 1'b0);
    gpData = 1'b1; #1; checkBit("R2 sel 00 gp1", pinOut, 1'b1);
    wr(2'd0, 8'h40, dummy);
    gpData = 1'b0; #1; checkBit("R2 sel 01 gp0", pinOut, 1'b0);
    gpData = 1'b1; #1; checkBit("R2 sel 01 gp1", pinOut, 1'b1);
    pinIsOut = 1'b0;
    wr(2'd0, 8'hC0, dummy);
    gpData = 1'b0; #1; checkBit("R2 input pin gp0", pinOut, 1'b0);
    gpData = 1'b1; #1; checkBit("R2 input pin gp1", pinOut, 1'b1);
    pinIsOut = 1'b1;
    gpData = 1'b0;

    // R10: time-base clock at the pin (select 11 still active)
    @(negedge clk);
    ones = 0; edges = 0; prev = pinOut;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (pinOut === 1'b1) ones++;
      if (pinOut !== prev) edges++;
      prev = pinOut;
    end
    checkNum("R10 high cycles in 64", ones, 32);
    checkNum("R10 transitions in 64", edges, 16);

    // R4 R6 R8: single pass, 8*2*3 = 48 cycles
    startTimer(2, 3, 1'b0, 1, "R4 R6", w);
    checkBit("R3 load presets toggle", pinOut, 1'b1);
    waitUntil(w + 48 + 150);
    checkNum("R8 single pass pending", expQ.size(), 0);
    checkBit("R6 toggle low after one eoc", pinOut, 1'b0);

    // R5: zero encodes the maximum
    startTimer(0, 1, 1'b0, 1, "R5 prescale 0", w);
    waitUntil(w + 512 + 40);
    checkNum("R5 prescale 0 pending", expQ.size(), 0);
    startTimer(1, 0, 1'b0, 1, "R5 count 0", w);
    waitUntil(w + 2048 + 40);
    checkNum("R5 count 0 pending", expQ.size(), 0);

    // R7: continuous, period 24, duty measured over two periods
    startTimer(1, 3, 1'b1, 4, "R7 R3", w);
    waitUntil(w + 24);
    ones = 0;
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      if (pinOut === 1'b1) ones++;
    end
    checkNum("R7 high cycles over two periods", ones, 24);
    // R3: mode write without load bit must not disturb the 4th eoc
    wr(2'd0, 8'h80, dummy);
    waitUntil(w + 96 + 200);
    checkNum("R7 R8 continuous stop pending", expQ.size(), 0);

    // R9: count rewrite applies from the next reload
    startTimer(1, 2, 1'b1, 2, "R9", w);
    waitUntil(w + 20);
    wr(2'd2, 8'd4, dummy);
    pushExp(w + 64, 1'b0, "R9 new period");
    waitUntil(w + 40);
    wr(2'd0, 8'h80, dummy);
    waitUntil(w + 64 + 150);
    checkNum("R9 pending", expQ.size(), 0);

    // R3: restart while running
    startTimer(1, 2, 1'b1, 1, "R3 first run", w);
    waitUntil(w + 20);
    checkBit("R3 toggle low before restart", pinOut, 1'b0);
    wr(2'd0, 8'h84, w2);
    checkBit("R3 restart presets toggle", pinOut, 1'b1);
    pushExp(w2 + 16, 1'b0, "R3 restart interval");
    waitUntil(w2 + 16 + 150);
    checkNum("R3 restart pending", expQ.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule